// File: doc/BRIEF.md
# Flash Command Interface Sequencer

This block sits behind the write port of a multi-bank NOR flash and turns each bus write cycle into a step of the command interface state machine. The low byte of the written word is the command code. The block address that comes with the write matters only in the factory-programming path. From the decoded command and the current state, the sequencer moves between idle, lock/configuration setup, one-time-programmable setup and busy, program and erase setup, busy and suspend, lock setup nested inside an erase suspend, and the factory-programming busy and verify phases.

The program/erase controller is not part of this block. The sequencer starts it with one-cycle pulses: program, erase, lock or configuration. The controller reports back on a single completion input. The sequencer also keeps two sticky flags: one for a bad lock/configuration sequence and one for other command errors. A clear-status command resets both flags.

All outputs are registered. Each write is acted on at the clock edge where it is sampled, and its effects appear on the outputs for the following cycle.

Top module: `flash_cmd_seq`

## Requirements
- R1: While reset (synchronous, active-high) is sampled high, the next cycle shows state code 0 (idle) with both flags low and no start pulse. The state codes are: idle 0, lock-setup 1, otp-setup 2, otp-busy 3, prog-setup 4, prog-busy 5, prog-suspended 6, erase-setup 7, erase-busy 8, erase-suspended 9, lock-setup-in-suspend 10, factory-setup 11, factory-busy 12, factory-verify 13.
- R2: In idle, the command byte (wr_data[7:0], upper bits ignored) moves the state as follows: 60h to 1, C0h to 2, 40h to 4, 20h to 7, 30h to 11. The defined codes 01h, D0h, 2Fh, 03h, B0h and 50h leave the state at idle and raise no error.
- R3: In lock-setup, 01h, D0h or 2Fh returns to idle with a one-cycle lock pulse, and 03h returns to idle with a one-cycle configuration pulse. At most one start pulse is high in any cycle.
- R4: In lock-setup, any other byte returns to idle, sets the lock-error flag and gives no pulse.
- R5: In erase-suspended, 60h enters state 10. The next write returns to 9: a confirm code gives the matching pulse, and any other byte sets the lock-error flag.
- R6: While the controller is busy (states 3, 5, 8), a 60h write or a confirm byte leaves the state unchanged and gives no pulse.
- R7: In otp-setup, any write moves to otp-busy with a program pulse. A completion in otp-busy returns to idle.
- R8: In prog-setup, any write gives a program pulse and moves to 5. In erase-setup, D0h gives an erase pulse and moves to 8, and any other byte returns to idle and sets the error flag. A completion in 5 or 8 returns to idle and takes priority over a suspend in the same cycle.
- R9: B0h suspends 5 to 6 and 8 to 9. D0h resumes 6 to 5 and 9 to 8 without a pulse.
- R10: In factory-setup, D0h with sr0 low enters 12 and records the write's block address. Any other write, or D0h with sr0 high, returns to idle and sets the error flag.
- R11: In 12, a write to the recorded block gives a program pulse whatever its data. A write to another block with data FFFFh moves to 13, and a write to another block with other data is ignored. In 13, writes give no pulse, and a write to another block with data FFFFh returns to idle.
- R12: In idle, an undefined command byte keeps the state at idle and sets the error flag.
- R13: Both flags stay set until a 50h write in idle, prog-suspended or erase-suspended clears them both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per bus write |
| wr_data | input | DATA_W | Written word; low byte is the command code |
| wr_blk | input | BLK_W | Block address of the write |
| pe_done | input | 1 | Program/erase controller completion |
| sr0 | input | 1 | Status bit that must be low for factory programming |
| state_o | output | 4 | Current interface state code |
| lock_err | output | 1 | Sticky lock/configuration sequence error |
| gen_err | output | 1 | Sticky command error |
| start_prog | output | 1 | One-cycle program start |
| start_erase | output | 1 | One-cycle erase start |
| start_lock | output | 1 | One-cycle lock/unlock/lock-down start |
| start_cfg | output | 1 | One-cycle configuration register write |

## Verification
Every result comes one register stage after the write or completion that causes it. This covers the state code, the flags and the start pulses. The pulse is high only in the cycle right after the triggering edge. The bench drives each write on a falling edge and holds it through one rising edge. It samples all outputs at the next falling edge, which is the one cycle in which a pulse is visible. Each step is therefore checked once, with no slack that could hide a missing or stretched pulse. All 256 command bytes are swept from idle, from lock-setup and from the nested lock setup inside an erase suspend. The expected results come from a code table kept in the bench.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CMD_W   = 8;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE      = 4'd0,
        ST_LK_SETUP  = 4'd1,
        ST_OTP_SETUP = 4'd2,
        ST_OTP_BUSY  = 4'd3,
        ST_PRG_SETUP = 4'd4,
        ST_PRG_BUSY  = 4'd5,
        ST_PRG_SUSP  = 4'd6,
        ST_ERS_SETUP = 4'd7,
        ST_ERS_BUSY  = 4'd8,
        ST_ERS_SUSP  = 4'd9,
        ST_LK_IN_ES  = 4'd10,
        ST_FP_SETUP  = 4'd11,
        ST_FP_BUSY   = 4'd12,
        ST_FP_VERIFY = 4'd13
    } fcs_state_e;

    typedef enum logic [3:0] {
        C_LK_SETUP,
        C_LOCK,
        C_CONFIRM,
        C_LOCKDN,
        C_SET_CFG,
        C_OTP,
        C_FP,
        C_ERASE,
        C_PROG,
        C_SUSPEND,
        C_CLR_STAT,
        C_UNDEF
    } fcs_cmd_e;

    typedef struct packed {
        fcs_state_e state;
        logic       lock_err;
        logic       gen_err;
        logic       go_prog;
        logic       go_erase;
        logic       go_lock;
        logic       go_cfg;
    } fcs_regs_t;

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
    import fcs_pkg::*;
(
    input  logic [CMD_W-1:0] code,
    output fcs_cmd_e         cmd
);
    always_comb begin
        unique case (code)
            8'h60:   cmd = C_LK_SETUP;
            8'h01:   cmd = C_LOCK;
            8'hD0:   cmd = C_CONFIRM;
            8'h2F:   cmd = C_LOCKDN;
            8'h03:   cmd = C_SET_CFG;
            8'hC0:   cmd = C_OTP;
            8'h30:   cmd = C_FP;
            8'h20:   cmd = C_ERASE;
            8'h40:   cmd = C_PROG;
            8'hB0:   cmd = C_SUSPEND;
            8'h50:   cmd = C_CLR_STAT;
            default: cmd = C_UNDEF;
        endcase
    end
endmodule

// File: rtl/fcs_fp_track.sv
module fcs_fp_track #(
    parameter int DATA_W = 16,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic [DATA_W-1:0] wr_data,
    output logic              same_blk,
    output logic              exit_pat
);
    logic [BLK_W-1:0] home_d, home_q;

    always_comb begin
        home_d = capture ? wr_blk : home_q;
    end

    always_ff @(posedge clk) begin
        if (rst) home_q <= '0;
        else     home_q <= home_d;
    end

    assign same_blk = (wr_blk == home_q);
    assign exit_pat = !same_blk && (&wr_data);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int BLK_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BLK_W-1:0]  wr_blk,
    input  logic              pe_done,
    input  logic              sr0,
    output logic [3:0]        state_o,
    output logic              lock_err,
    output logic              gen_err,
    output logic              start_prog,
    output logic              start_erase,
    output logic              start_lock,
    output logic              start_cfg
);
    fcs_regs_t r_d, r_q;
    fcs_cmd_e  cmd;
    logic      fp_capture;
    logic      fp_same_blk;
    logic      fp_exit;
    logic      lk_ok;

    fcs_decode u_dec (
        .code (wr_data[CMD_W-1:0]),
        .cmd  (cmd)
    );

    fcs_fp_track #(.DATA_W(DATA_W), .BLK_W(BLK_W)) u_fp (
        .clk      (clk),
        .rst      (rst),
        .capture  (fp_capture),
        .wr_blk   (wr_blk),
        .wr_data  (wr_data),
        .same_blk (fp_same_blk),
        .exit_pat (fp_exit)
    );

    assign lk_ok = (cmd == C_LOCK) || (cmd == C_CONFIRM) || (cmd == C_LOCKDN);
    assign fp_capture = wr_en && (r_q.state == ST_FP_SETUP)
                        && (cmd == C_CONFIRM) && !sr0;

    always_comb begin
        r_d          = r_q;
        r_d.go_prog  = 1'b0;
        r_d.go_erase = 1'b0;
        r_d.go_lock  = 1'b0;
        r_d.go_cfg   = 1'b0;

        unique case (r_q.state)
            ST_IDLE: if (wr_en) begin
                case (cmd)
                    C_LK_SETUP: r_d.state = ST_LK_SETUP;
                    C_OTP:      r_d.state = ST_OTP_SETUP;
                    C_PROG:     r_d.state = ST_PRG_SETUP;
                    C_ERASE:    r_d.state = ST_ERS_SETUP;
                    C_FP:       r_d.state = ST_FP_SETUP;
                    C_CLR_STAT: begin
                        r_d.lock_err = 1'b0;
                        r_d.gen_err  = 1'b0;
                    end
                    C_UNDEF:    r_d.gen_err = 1'b1;
                    default:    ;
                endcase
            end
            ST_LK_SETUP, ST_LK_IN_ES: if (wr_en) begin
                r_d.state = (r_q.state == ST_LK_IN_ES) ? ST_ERS_SUSP : ST_IDLE;
                if (lk_ok)                 r_d.go_lock  = 1'b1;
                else if (cmd == C_SET_CFG) r_d.go_cfg   = 1'b1;
                else                       r_d.lock_err = 1'b1;
            end
            ST_OTP_SETUP: if (wr_en) begin
                r_d.state   = ST_OTP_BUSY;
                r_d.go_prog = 1'b1;
            end
            ST_PRG_SETUP: if (wr_en) begin
                r_d.state   = ST_PRG_BUSY;
                r_d.go_prog = 1'b1;
            end
            ST_ERS_SETUP: if (wr_en) begin
                if (cmd == C_CONFIRM) begin
                    r_d.state    = ST_ERS_BUSY;
                    r_d.go_erase = 1'b1;
                end else begin
                    r_d.state   = ST_IDLE;
                    r_d.gen_err = 1'b1;
                end
            end
            ST_OTP_BUSY: if (pe_done) r_d.state = ST_IDLE;
            ST_PRG_BUSY, ST_ERS_BUSY: begin
                if (pe_done)
                    r_d.state = ST_IDLE;
                else if (wr_en && cmd == C_SUSPEND)
                    r_d.state = (r_q.state == ST_PRG_BUSY) ? ST_PRG_SUSP : ST_ERS_SUSP;
            end
            ST_PRG_SUSP: if (wr_en) begin
                if (cmd == C_CONFIRM) r_d.state = ST_PRG_BUSY;
                else if (cmd == C_CLR_STAT) begin
                    r_d.lock_err = 1'b0;
                    r_d.gen_err  = 1'b0;
                end
            end
            ST_ERS_SUSP: if (wr_en) begin
                if (cmd == C_CONFIRM)       r_d.state = ST_ERS_BUSY;
                else if (cmd == C_LK_SETUP) r_d.state = ST_LK_IN_ES;
                else if (cmd == C_CLR_STAT) begin
                    r_d.lock_err = 1'b0;
                    r_d.gen_err  = 1'b0;
                end
            end
            ST_FP_SETUP: if (wr_en) begin
                if (fp_capture) r_d.state = ST_FP_BUSY;
                else begin
                    r_d.state   = ST_IDLE;
                    r_d.gen_err = 1'b1;
                end
            end
            ST_FP_BUSY: if (wr_en) begin
                if (fp_same_blk)  r_d.go_prog = 1'b1;
                else if (fp_exit) r_d.state   = ST_FP_VERIFY;
            end
            ST_FP_VERIFY: if (wr_en && fp_exit) r_d.state = ST_IDLE;
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q          <= '0;
            r_q.state    <= ST_IDLE;
        end else begin
            r_q          <= r_d;
        end
    end

    assign state_o     = r_q.state;
    assign lock_err    = r_q.lock_err;
    assign gen_err     = r_q.gen_err;
    assign start_prog  = r_q.go_prog;
    assign start_erase = r_q.go_erase;
    assign start_lock  = r_q.go_lock;
    assign start_cfg   = r_q.go_cfg;
endmodule

// File: rtl/fcs_chk.sv
module fcs_chk (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic [7:0] cmd_byte,
    input logic       pe_done,
    input logic [3:0] state_o,
    input logic       lock_err,
    input logic       gen_err,
    input logic       start_prog,
    input logic       start_erase,
    input logic       start_lock,
    input logic       start_cfg
);
    logic seen_clk = 1'b0;
    always_ff @(posedge clk) seen_clk <= 1'b1;

    always @(posedge clk) begin
        if (seen_clk && $past(rst)) begin
            p_reset_idle_r1: assert (state_o == 4'd0 && !lock_err && !gen_err
                && !start_prog && !start_erase && !start_lock && !start_cfg)
                else $error("reset did not return to idle");
        end
    end

    p_pulse_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_prog, start_erase, start_lock, start_cfg}));

    p_lockerr_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        (lock_err && !(wr_en && cmd_byte == 8'h50)) |=> lock_err);

    p_es_lock_return_r5: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd10 && wr_en) |=> (state_o == 4'd9));

    p_busy_ignores_lock_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd_byte == 8'h60 && !pe_done
         && (state_o == 4'd3 || state_o == 4'd5 || state_o == 4'd8))
        |=> $stable(state_o));

    p_otp_done_r7: assert property (@(posedge clk) disable iff (rst)
        (state_o == 4'd3 && pe_done) |=> (state_o == 4'd0));

    p_erase_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        start_erase |-> (state_o == 4'd8));
endmodule

bind flash_cmd_seq fcs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .cmd_byte    (wr_data[7:0]),
    .pe_done     (pe_done),
    .state_o     (state_o),
    .lock_err    (lock_err),
    .gen_err     (gen_err),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .start_lock  (start_lock),
    .start_cfg   (start_cfg)
);

// File: tb/tb_flash_cmd_seq.sv
`timescale 1ns/1ps
module tb_flash_cmd_seq;
    localparam int DW = 16;
    localparam int BW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [BW-1:0] wr_blk = '0;
    logic          pe_done = 1'b0;
    logic          sr0 = 1'b0;
    logic [3:0]    state_o;
    logic          lock_err, gen_err;
    logic          start_prog, start_erase, start_lock, start_cfg;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    flash_cmd_seq #(.DATA_W(DW), .BLK_W(BW)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
        .pe_done(pe_done), .sr0(sr0), .state_o(state_o), .lock_err(lock_err),
        .gen_err(gen_err), .start_prog(start_prog), .start_erase(start_erase),
        .start_lock(start_lock), .start_cfg(start_cfg)
    );

    function automatic logic [3:0] pulses();
        return {start_prog, start_erase, start_lock, start_cfg};
    endfunction

    task automatic ck(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; pe_done = 1'b0;
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic [BW-1:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_blk = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic done_pulse(input logic with_wr, input logic [DW-1:0] d);
        @(negedge clk);
        pe_done = 1'b1; wr_en = with_wr; wr_data = d;
        @(negedge clk);
        pe_done = 1'b0; wr_en = 1'b0;
    endtask

    function automatic int idle_next(input int c);
        case (c)
            8'h60: return 1;
            8'hC0: return 2;
            8'h40: return 4;
            8'h20: return 7;
            8'h30: return 11;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_defined(input int c);
        return c == 8'h60 || c == 8'h01 || c == 8'hD0 || c == 8'h2F || c == 8'h03 ||
               c == 8'hC0 || c == 8'h30 || c == 8'h20 || c == 8'h40 || c == 8'hB0 ||
               c == 8'h50;
    endfunction

    function automatic int lk_pulse(input int c);
        if (c == 8'h01 || c == 8'hD0 || c == 8'h2F) return 4'b0010;
        if (c == 8'h03) return 4'b0001;
        return 0;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset();
        @(negedge clk);
        ck("R1 state", state_o, 0);
        ck("R1 flags", {lock_err, gen_err}, 0);
        ck("R1 pulses", pulses(), 0);

        // R2 / R12: every byte from idle, upper data bits set to show they are ignored
        for (int c = 0; c < 256; c++) begin
            do_reset();
            wr({8'hA5, c[7:0]}, 6'd0);
            ck("R2 idle dispatch", state_o, idle_next(c));
            ck("R12 undefined byte error", gen_err, is_defined(c) ? 0 : 1);
            ck("R2 no pulse", pulses(), 0);
        end

        // R3 / R4: every byte in lock-setup
        for (int c = 0; c < 256; c++) begin
            do_reset();
            wr(16'h0060, 6'd0);
            wr({8'h00, c[7:0]}, 6'd0);
            ck("R3 back to idle", state_o, 0);
            ck("R3 pulse", pulses(), lk_pulse(c));
            ck("R4 lock error", lock_err, (lk_pulse(c) == 0) ? 1 : 0);
        end

        // R5 / R8 / R9: every byte in lock setup nested in erase suspend
        for (int c = 0; c < 256; c++) begin
            do_reset();
            wr(16'h0020, 6'd0);
            wr(16'h00D0, 6'd0);
            ck("R8 erase busy", state_o, 8);
            ck("R8 erase pulse", pulses(), 4'b0100);
            wr(16'h00B0, 6'd0);
            ck("R9 erase suspended", state_o, 9);
            wr(16'h0060, 6'd0);
            ck("R5 nested lock setup", state_o, 10);
            wr({8'h00, c[7:0]}, 6'd0);
            ck("R5 return to suspend", state_o, 9);
            ck("R5 pulse", pulses(), lk_pulse(c));
            ck("R5 lock error", lock_err, (lk_pulse(c) == 0) ? 1 : 0);
        end
        wr(16'h00D0, 6'd0);
        ck("R9 resume erase", state_o, 8);
        ck("R9 resume no pulse", pulses(), 0);
        done_pulse(1'b0, 16'h0);
        ck("R8 erase done", state_o, 0);
        ck("R13 lock error sticky", lock_err, 1);

        // R13: sticky flags, clear from prog-suspended; R8 done beats suspend
        do_reset();
        wr(16'h0060, 6'd0);
        wr(16'h0077, 6'd0);
        wr(16'h0012, 6'd0);
        ck("R13 both set", {lock_err, gen_err}, 3);
        wr(16'h0040, 6'd0);
        ck("R2 prog setup", state_o, 4);
        wr(16'h1234, 6'd0);
        ck("R8 prog busy", state_o, 5);
        ck("R8 prog pulse", pulses(), 4'b1000);
        ck("R13 still set", {lock_err, gen_err}, 3);
        wr(16'h00B0, 6'd0);
        ck("R9 prog suspended", state_o, 6);
        wr(16'h0050, 6'd0);
        ck("R13 cleared", {lock_err, gen_err}, 0);
        ck("R13 state kept", state_o, 6);
        wr(16'h00D0, 6'd0);
        ck("R9 prog resumed", state_o, 5);
        ck("R9 no pulse", pulses(), 0);
        done_pulse(1'b1, 16'h00B0);
        ck("R8 done over suspend", state_o, 0);

        // R6 / R7: otp path and busy ignoring lock commands
        do_reset();
        wr(16'h00C0, 6'd0);
        wr(16'hBEEF, 6'd0);
        ck("R7 otp busy", state_o, 3);
        ck("R7 otp pulse", pulses(), 4'b1000);
        wr(16'h0060, 6'd0);
        ck("R6 otp ignores setup", state_o, 3);
        wr(16'h0001, 6'd0);
        ck("R6 otp ignores confirm", state_o, 3);
        ck("R6 no pulse", pulses(), 0);
        done_pulse(1'b0, 16'h0);
        ck("R7 otp done", state_o, 0);
        do_reset();
        wr(16'h0020, 6'd0);
        wr(16'h00D0, 6'd0);
        wr(16'h0060, 6'd0);
        ck("R6 erase ignores setup", state_o, 8);
        wr(16'h0003, 6'd0);
        ck("R6 erase ignores confirm", state_o, 8);
        ck("R6 erase no pulse", pulses(), 0);
        do_reset();
        wr(16'h0020, 6'd0);
        wr(16'h0040, 6'd0);
        ck("R8 bad erase confirm", state_o, 0);
        ck("R8 bad erase error", gen_err, 1);

        // R10: factory entry refused
        do_reset();
        sr0 = 1'b1;
        wr(16'h0030, 6'd5);
        ck("R2 factory setup", state_o, 11);
        wr(16'h00D0, 6'd5);
        ck("R10 sr0 high refused", state_o, 0);
        ck("R10 sr0 error", gen_err, 1);
        sr0 = 1'b0;
        do_reset();
        wr(16'h0030, 6'd5);
        wr(16'h0030, 6'd5);
        ck("R10 wrong confirm", state_o, 0);
        ck("R10 wrong confirm error", gen_err, 1);

        // R10 / R11: factory streaming and exit
        do_reset();
        wr(16'h0030, 6'd5);
        wr(16'h00D0, 6'd5);
        ck("R10 factory busy", state_o, 12);
        ck("R10 entry no pulse", pulses(), 0);
        for (int i = 0; i < 6; i++) begin
            logic [DW-1:0] d;
            d = (i == 0) ? 16'h0050 : (i == 1) ? 16'h0060 : (i == 2) ? 16'hFFFF : DW'(i * 16'h1111);
            wr(d, 6'd5);
            ck("R11 data word pulse", pulses(), 4'b1000);
            ck("R11 stays busy", state_o, 12);
        end
        wr(16'h1234, 6'd6);
        ck("R11 foreign block ignored", state_o, 12);
        ck("R11 foreign no pulse", pulses(), 0);
        wr(16'hFFFF, 6'd6);
        ck("R11 enter verify", state_o, 13);
        wr(16'h00D0, 6'd5);
        ck("R11 verify stays", state_o, 13);
        ck("R11 verify no pulse", pulses(), 0);
        wr(16'h7FFF, 6'd7);
        ck("R11 verify non-exit", state_o, 13);
        wr(16'hFFFF, 6'd7);
        ck("R11 verify exit", state_o, 0);
        ck("R11 no error", gen_err, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule